// File: doc/BRIEF.md
# Dual-Channel Power-of-Two Clock Divider

This block derives two slower clocks from one fast input clock. Output A runs at the input rate or at one half, one quarter or one eighth of it. Output B runs at one half, one quarter, one eighth or one sixteenth of it. Each output has its own two-bit ratio code. Both outputs are taken from the bits of a single free-running 4-bit counter. Because of this, every rising edge of either output falls on a rising edge of the input clock. All ratios also rise together each time the counter wraps.

A synchronous, active-high master reset parks the counter so that both outputs are low. Several instances that leave reset on the same input edge then run in lockstep. A single enable input gates both outputs. The enable is captured on a falling input edge, and only while the output concerned is low. An output can therefore start or stop only at a pulse boundary, and it never emits a shortened high pulse. A new ratio code is adopted only at the 16-cycle frame boundary, where every ratio is about to rise.

Top module: `dual_clk_divider`

## Requirements
- R1: Channel A ratio code 01 gives input/2, 10 gives input/4 and 11 gives input/8. Each divided output is high for the first half of its period, measured from the counter wrap.
- R2: Channel B ratio code 00 gives input/2, 01 gives input/4, 10 gives input/8 and 11 gives input/16. Each output is high for the first half of its period, measured from the counter wrap.
- R3: While the reset input is high at a clock edge, both outputs are low. After release, the first rising edge of both outputs is the first rising input edge that follows a falling edge at which reset was seen low.
- R4: Every rising edge of either output coincides with a rising input edge. At each 16-cycle frame start, all enabled outputs rise together.
- R5: A change of a ratio code takes effect only at the rising input edge where the counter wraps from 15 to 0. Until then, the old ratio continues unchanged.
- R6: The enable input is sampled on a falling input edge, and only while the output concerned is low. At code 00 on channel A this is every falling edge. A disabled output stays low, and no high pulse is ever cut short.
- R7: Every divided output has a 50 percent duty cycle: it is high for exactly half of its period in input cycles.
- R8: Channel A code 00 passes the input clock through: the output is high during the input high phase and low during the input low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous active-high master reset |
| en_i | input | 1 | Output enable for both channels, captured on a falling edge |
| sel_a_i | input | 2 | Channel A ratio code (00=/1, 01=/2, 10=/4, 11=/8) |
| sel_b_i | input | 2 | Channel B ratio code (00=/2, 01=/4, 10=/8, 11=/16) |
| clk_a_o | output | 1 | Channel A divided clock |
| clk_b_o | output | 1 | Channel B divided clock |

## Verification
A corrupted counter value shows up within one input cycle as an edge on the divide-by-2 tap that arrives out of turn. At the coarser ratios it moves the next frame start, and that misplaces both outputs within at most 16 cycles. A stale or early ratio register shows up as a pulse of the wrong width that starts before the frame boundary. A wrong enable register shows up as a pulse that is missing, extra or truncated in the half-cycle after the falling edge where it was captured. The bench compares both outputs against a behavioural model in every half-cycle. Select changes are applied at many frame phases, and enable toggles are applied in both output phases.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int unsigned DEF_CNT_W = 4;
  localparam int unsigned DEF_SEL_W = 2;

  // exponent of the division ratio selected by a code on a channel with base b
  function automatic int unsigned ratio_exp(input int unsigned code, input int unsigned base);
    return code + base;
  endfunction

endpackage

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int unsigned CNT_W = clkdiv_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             zero_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  // reset parks the counter at its top value so every inverted tap is low
  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= CNT_MAX;
    else       cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == CNT_MAX);
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel #(
  parameter int unsigned CNT_W = clkdiv_pkg::DEF_CNT_W,
  parameter int unsigned SEL_W = clkdiv_pkg::DEF_SEL_W,
  parameter int unsigned BASE  = 0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  input  logic             zero_i,
  output logic             clk_o
);

  localparam int unsigned N_CODES = 1 << SEL_W;

  logic [SEL_W-1:0]   sel_act_q;
  logic [N_CODES-1:0] tap_v;
  logic [N_CODES-1:0] pass_v;
  logic               raw;
  logic               pass_thru;
  logic               gate_q;

  // ratio code is adopted only at the frame boundary (or while in reset)
  always_ff @(posedge clk_i) begin
    if (rst_i || wrap_i) sel_act_q <= sel_i;
  end

  // one tap per code: the inverted counter bit rises when the low bits wrap
  for (genvar c = 0; c < N_CODES; c++) begin : g_tap
    localparam int unsigned EXP = clkdiv_pkg::ratio_exp(c, BASE);
    if (EXP == 0) begin : g_pass
      assign tap_v[c]  = 1'b0;
      assign pass_v[c] = 1'b1;
    end else begin : g_div
      assign tap_v[c]  = ~cnt_i[EXP-1];
      assign pass_v[c] = 1'b0;
    end
  end

  assign raw       = tap_v[sel_act_q];
  assign pass_thru = pass_v[sel_act_q];

  // enable captured on the falling edge, only while the output is low
  always_ff @(negedge clk_i) begin
    if (rst_i)                 gate_q <= 1'b0;
    else if (pass_thru || !raw) gate_q <= en_i;
  end

  assign clk_o = gate_q & (pass_thru ? clk_i : raw);

  // R6: the gate of a divided output only moves while that output is low
  p_gate_moves_low_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(gate_q) && !pass_thru) |-> !raw);

  // R5: the active ratio only changes at the frame start
  p_sel_at_frame_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(sel_act_q) && !$past(rst_i)) |-> zero_i);

endmodule

// File: rtl/dual_clk_divider.sv
module dual_clk_divider #(
  parameter int unsigned CNT_W  = clkdiv_pkg::DEF_CNT_W,
  parameter int unsigned SEL_W  = clkdiv_pkg::DEF_SEL_W,
  parameter int unsigned BASE_A = 0,
  parameter int unsigned BASE_B = 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_a_i,
  input  logic [SEL_W-1:0] sel_b_i,
  output logic             clk_a_o,
  output logic             clk_b_o
);

  localparam int unsigned MAX_EXP_A = BASE_A + (1 << SEL_W) - 1;
  localparam int unsigned MAX_EXP_B = BASE_B + (1 << SEL_W) - 1;

  initial begin
    if (MAX_EXP_A > CNT_W || MAX_EXP_B > CNT_W)
      $error("counter too narrow for the selected ratio range");
  end

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             zero;

  clkdiv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cnt_o  (cnt),
    .wrap_o (wrap),
    .zero_o (zero)
  );

  clkdiv_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BASE(BASE_A)) u_cha (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .sel_i  (sel_a_i),
    .cnt_i  (cnt),
    .wrap_i (wrap),
    .zero_i (zero),
    .clk_o  (clk_a_o)
  );

  clkdiv_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BASE(BASE_B)) u_chb (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .sel_i  (sel_b_i),
    .cnt_i  (cnt),
    .wrap_i (wrap),
    .zero_i (zero),
    .clk_o  (clk_b_o)
  );

  // R3: one cycle into reset both outputs are low
  p_reset_low_r3: assert property (@(posedge clk_i)
    rst_i |=> (!clk_a_o && !clk_b_o));

  // R4: channel B rises only where the divide-by-2 tap rises
  p_b_rise_aligned_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(clk_b_o) |-> $past(cnt[0]));

endmodule

// File: tb/dual_clk_divider_tb.sv
module dual_clk_divider_tb;

  localparam int T = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [1:0] sa  = 2'd0;
  logic [1:0] sb  = 2'd0;
  logic       clk_a_o;
  logic       clk_b_o;

  always #(T/2) clk = ~clk;

  dual_clk_divider u_dut (
    .clk_i   (clk),
    .rst_i   (rst),
    .en_i    (en),
    .sel_a_i (sa),
    .sel_b_i (sb),
    .clk_a_o (clk_a_o),
    .clk_b_o (clk_b_o)
  );

  int    vectors = 0;
  int    fails   = 0;
  bit    armed   = 1'b0;
  bit    done    = 1'b0;
  string cur_req = "R3";

  // behavioural reference: frame phase 0..15, active exponents, gates
  int m_phase = 15;
  int m_ka    = 0;
  int m_kb    = 1;
  bit m_ga    = 1'b0;
  bit m_gb    = 1'b0;

  function automatic bit m_high(int k, int ph);
    return (ph % (1 << k)) < (1 << (k - 1));
  endfunction

  always @(posedge clk) begin
    if (rst || m_phase == 15) begin
      m_ka = sa;
      m_kb = sb + 1;
    end
    m_phase = rst ? 15 : (m_phase + 1) % 16;
  end

  always @(negedge clk) begin
    if (rst) begin
      m_ga = 1'b0;
      m_gb = 1'b0;
    end else begin
      if (m_ka == 0 || !m_high(m_ka, m_phase)) m_ga = en;
      if (!m_high(m_kb, m_phase)) m_gb = en;
    end
  end

  task automatic compare(input bit hi);
    bit ea, eb;
    if (!armed || done) return;
    ea = m_ga & ((m_ka == 0) ? hi : m_high(m_ka, m_phase));
    eb = m_gb & m_high(m_kb, m_phase);
    vectors += 2;
    if (clk_a_o !== ea) begin
      fails++;
      $display("FAIL %s clk_a_o t=%0t actual=%b expected=%b", cur_req, $time, clk_a_o, ea);
    end
    if (clk_b_o !== eb) begin
      fails++;
      $display("FAIL %s clk_b_o t=%0t actual=%b expected=%b", cur_req, $time, clk_b_o, eb);
    end
    // R4: at a frame start with both gates open, both outputs are high together
    if (cur_req == "R4" && hi && m_phase == 0 && m_ga && m_gb) begin
      vectors++;
      if (!(clk_a_o === 1'b1 && clk_b_o === 1'b1)) begin
        fails++;
        $display("FAIL R4 frame-start t=%0t actual=%b%b expected=11", $time, clk_a_o, clk_b_o);
      end
    end
  endtask

  always @(posedge clk) begin #(T/4); compare(1'b1); end
  always @(negedge clk) begin #(T/4); compare(1'b0); end

  task automatic run(input int n, input bit r, input bit e, input int a, input int b);
    repeat (n) begin
      @(posedge clk);
      #2;
      rst = r; en = e; sa = a[1:0]; sb = b[1:0];
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(T * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R3: reset holds both outputs low
    cur_req = "R3";
    run(2, 1'b1, 1'b1, 0, 0);
    armed = 1'b1;
    run(4, 1'b1, 1'b1, 1, 2);
    // R8: pass-through on A, /2 on B
    cur_req = "R8";
    run(40, 1'b0, 1'b1, 0, 0);
    // R1: each divided ratio on channel A
    cur_req = "R1";
    for (int a = 1; a < 4; a++) run(40, 1'b0, 1'b1, a, 1);
    // R2: each ratio on channel B
    cur_req = "R2";
    for (int b = 0; b < 4; b++) run(40, 1'b0, 1'b1, 1, b);
    // R4: edge alignment across mixed ratios
    cur_req = "R4";
    run(40, 1'b0, 1'b1, 0, 3);
    run(40, 1'b0, 1'b1, 2, 1);
    run(40, 1'b0, 1'b1, 3, 2);
    // R7: steady coarse ratios, duty checked every half cycle
    cur_req = "R7";
    run(48, 1'b0, 1'b1, 3, 3);
    // R5: ratio codes changed at many different frame phases
    cur_req = "R5";
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) run(13, 1'b0, 1'b1, a, 3 - b);
    // R6: enable toggling in both phases of the outputs
    cur_req = "R6";
    for (int i = 0; i < 60; i++) run(1, 1'b0, ((i * 7) % 5) < 2, 2, 1);
    for (int i = 0; i < 60; i++) run(1, 1'b0, ((i * 3) % 11) < 5, 0, 3);
    for (int i = 0; i < 40; i++) run(1, 1'b0, (i % 9) < 4, 1, 0);
    run(20, 1'b0, 1'b0, 3, 2);
    // R3: reset in mid run, then release with new ratios
    cur_req = "R3";
    run(3, 1'b1, 1'b1, 2, 3);
    run(40, 1'b0, 1'b1, 1, 2);
    run(1, 1'b1, 1'b1, 0, 0);
    run(30, 1'b0, 1'b1, 0, 0);
    @(posedge clk);
    #(T);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule